// File: doc/BRIEF.md
# Tenth-second time-of-day counter

This block keeps wall-clock style time from a slow periodic input tick, such as a video frame strobe or a rectified mains pulse at 50 Hz or 60 Hz. A region-selectable prescaler turns that tick into one step every tenth of a second. The steps drive a chain of counters for tenths, seconds, minutes and a twelve-hour field, and a final morning/afternoon flag flips each time the hours field wraps. Every field is kept as a plain binary number, so software can do arithmetic on it directly without decimal adjustment.

A processor reaches the counter through a small byte-wide register window. Reading the hours byte takes a snapshot of the whole time, so that a four-byte read is coherent while the live count keeps running. Writing the hours byte stops the count, and writing the tenths byte starts it again, so that software can set a new time without a carry landing halfway through. An alarm holds a full time value. When the count steps onto that value, the alarm sets a sticky interrupt flag if the interrupt is enabled. The flag then holds until software clears it.

Top module: `tod_clock`

## Requirements
- R1: With control bit 0 clear, the tenths field advances on every 5th accepted input tick. With it set, the tenths field advances on every 6th accepted tick. Any write to the control register (address 8), or to the tenths byte, restarts the prescaler, so the next step needs a full 5 or 6 ticks.
- R2: Tenths counts 0 to TENTHS_MOD-1, seconds counts 0 to SEC_MOD-1, and minutes counts 0 to MIN_MOD-1. When a field wraps to 0, the next field up advances by one in the same step.
- R3: Hours counts 0 to HOUR_MOD-1. When hours wraps, the afternoon flag (bit 7 of the hours byte) toggles.
- R4: The register map is: 0 tenths, 1 seconds, 2 minutes, 3 hours (bits 6:0 binary hours, bit 7 afternoon), 4 to 7 the alarm copies in the same order and layout, 8 control (bit 0 selects divide-by-6, bit 1 enables the alarm interrupt), and 9 status (bit 0 alarm flag). All values are binary and zero-extended, and other addresses read as 0. Alarm and control registers read back what was written.
- R5: A read of the hours byte captures all time fields. Reads of addresses 0 to 3 then return the captured values until a read of the tenths byte, which returns the captured tenths and releases the hold. Counting continues while the hold is active.
- R6: A write to the hours byte stops counting, and input ticks then change no field. A write to the tenths byte resumes counting from a cleared prescaler.
- R7: On each tenth step, the new time is compared with all alarm fields, including the afternoon flag. On equality, the flag is set only if control bit 1 is 1. The irq_o output equals the flag. Ticks that do not produce a step never set it.
- R8: Once set, the flag and irq_o stay high through later steps until a write to status with bit 0 = 1. Writing 0 to that bit leaves the flag unchanged.
- R9: A field value written above its maximum count wraps to 0 at the next carry into it, and passes a carry upward just as a normal wrap does.
- R10: After reset, all time, alarm, control and status registers read 0, counting is running with divide-by-5, and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse per frame or mains period |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (drives the snapshot side effects) |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| irq_o | output | 1 | Latched alarm interrupt |

## Verification
The bench builds the counter with tenths modulus 3, seconds modulus 4, minutes modulus 3 and hours modulus 3, and keeps both prescaler divisors at 5 and 6. With these values a full morning-and-afternoon cycle is only 216 tenth steps. The bench walks every one of them and compares each field against quotients and remainders of the elapsed step count, including the final wrap back to zero. The small two-bit fields also let the bench write an out-of-range minutes value and watch one step ripple a carry through every field, ending in a flip of the afternoon flag.

// File: rtl/tod_pkg.sv
package tod_pkg;

    typedef enum logic [3:0] {
        ADDR_TENTHS     = 4'd0,
        ADDR_SECONDS    = 4'd1,
        ADDR_MINUTES    = 4'd2,
        ADDR_HOURS      = 4'd3,
        ADDR_AL_TENTHS  = 4'd4,
        ADDR_AL_SECONDS = 4'd5,
        ADDR_AL_MINUTES = 4'd6,
        ADDR_AL_HOURS   = 4'd7,
        ADDR_CTRL       = 4'd8,
        ADDR_STATUS     = 4'd9
    } tod_addr_e;

    localparam int CTRL_REGION_BIT = 0;
    localparam int CTRL_IRQEN_BIT  = 1;
    localparam int HOURS_PM_BIT    = 7;
    localparam int STATUS_FLAG_BIT = 0;

endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
    parameter int DIV_SLOW = 5,
    parameter int DIV_FAST = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic run_i,
    input  logic sel_fast_i,
    input  logic clear_i,
    output logic step_o
);
    localparam int DMAX = (DIV_FAST > DIV_SLOW) ? DIV_FAST : DIV_SLOW;
    localparam int CW   = (DMAX > 1) ? $clog2(DMAX) : 1;
    localparam logic [CW-1:0] LIM_SLOW = CW'(DIV_SLOW - 1);
    localparam logic [CW-1:0] LIM_FAST = CW'(DIV_FAST - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] limit;

    always_comb begin
        limit  = sel_fast_i ? LIM_FAST : LIM_SLOW;
        step_o = tick_i && run_i && !clear_i && (cnt_q >= limit);
        cnt_d  = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (tick_i && run_i) begin
            cnt_d = step_o ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_PRESC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DMAX - 1)) else $error("prescaler out of range"); // R1
    AST_PRESC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> cnt_q == '0) else $error("prescaler not cleared"); // R1

endmodule

// File: rtl/tod_field.sv
module tod_field #(
    parameter int MOD = 10,
    parameter int W   = (MOD > 1) ? $clog2(MOD) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] value_o,
    output logic [W-1:0] next_o,
    output logic         carry_o
);
    localparam logic [W-1:0] TOP = W'(MOD - 1);

    logic [W-1:0] value_d, value_q;

    always_comb begin
        carry_o = inc_i && !load_i && (value_q >= TOP);
        value_d = value_q;
        if (load_i) begin
            value_d = load_val_i;
        end else if (carry_o) begin
            value_d = '0;
        end else if (inc_i) begin
            value_d = value_q + 1'b1;
        end
        next_o  = value_d;
        value_o = value_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) value_q <= '0;
        else        value_q <= value_d;
    end

    AST_FIELD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        carry_o |=> value_q == '0) else $error("field did not wrap"); // R2

endmodule

// File: rtl/tod_alarm.sv
module tod_alarm #(
    parameter int VW = 21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic          en_i,
    input  logic          clr_i,
    input  logic [VW-1:0] next_time_i,
    input  logic [VW-1:0] alarm_i,
    output logic          irq_o
);
    logic flag_d, flag_q;
    logic hit;

    always_comb begin
        hit    = step_i && en_i && (next_time_i == alarm_i);
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (hit)   flag_d = 1'b1;
        irq_o  = flag_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    AST_IRQ_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> flag_q) else $error("flag dropped"); // R8
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && !en_i) |=> !flag_q) else $error("masked flag set"); // R7
    AST_IRQ_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && !step_i) |=> !flag_q) else $error("flag set off step"); // R7

endmodule

// File: rtl/tod_clock.sv
module tod_clock
    import tod_pkg::*;
#(
    parameter int DIV_SLOW   = 5,
    parameter int DIV_FAST   = 6,
    parameter int TENTHS_MOD = 10,
    parameter int SEC_MOD    = 60,
    parameter int MIN_MOD    = 60,
    parameter int HOUR_MOD   = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       wr_en_i,
    input  logic       rd_en_i,
    input  logic [3:0] addr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    output logic       irq_o
);
    localparam int TW = (TENTHS_MOD > 1) ? $clog2(TENTHS_MOD) : 1;
    localparam int SW = (SEC_MOD > 1) ? $clog2(SEC_MOD) : 1;
    localparam int MW = (MIN_MOD > 1) ? $clog2(MIN_MOD) : 1;
    localparam int HW = (HOUR_MOD > 1) ? $clog2(HOUR_MOD) : 1;
    localparam int VW = 1 + HW + MW + SW + TW;
    localparam int TN_LO = 0;
    localparam int SC_LO = TW;
    localparam int MN_LO = TW + SW;
    localparam int HR_LO = TW + SW + MW;
    localparam int PM_B  = VW - 1;

    typedef struct packed {
        logic          run;
        logic          frozen;
        logic          region;
        logic          irq_en;
        logic [VW-1:0] snap;
        logic [VW-1:0] alarm;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          step, presc_clr, flag_clr;
    logic          ld_tn, ld_sc, ld_mn, ld_hr;
    logic [TW-1:0] tn_q, tn_nx;
    logic [SW-1:0] sc_q, sc_nx;
    logic [MW-1:0] mn_q, mn_nx;
    logic [HW-1:0] hr_q, hr_nx;
    logic          pm_q, pm_nx;
    logic          c_tn, c_sc, c_mn, c_hr;
    logic          unused_pm_carry;
    logic [VW-1:0] live_vec, next_vec, src_vec;

    tod_prescaler #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_presc (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(ctl_q.run),
        .sel_fast_i(ctl_q.region), .clear_i(presc_clr), .step_o(step));

    tod_field #(.MOD(TENTHS_MOD), .W(TW)) u_tenths (
        .clk(clk), .rst_n(rst_n), .inc_i(step), .load_i(ld_tn),
        .load_val_i(wdata_i[TW-1:0]), .value_o(tn_q), .next_o(tn_nx), .carry_o(c_tn));

    tod_field #(.MOD(SEC_MOD), .W(SW)) u_seconds (
        .clk(clk), .rst_n(rst_n), .inc_i(c_tn), .load_i(ld_sc),
        .load_val_i(wdata_i[SW-1:0]), .value_o(sc_q), .next_o(sc_nx), .carry_o(c_sc));

    tod_field #(.MOD(MIN_MOD), .W(MW)) u_minutes (
        .clk(clk), .rst_n(rst_n), .inc_i(c_sc), .load_i(ld_mn),
        .load_val_i(wdata_i[MW-1:0]), .value_o(mn_q), .next_o(mn_nx), .carry_o(c_mn));

    tod_field #(.MOD(HOUR_MOD), .W(HW)) u_hours (
        .clk(clk), .rst_n(rst_n), .inc_i(c_mn), .load_i(ld_hr),
        .load_val_i(wdata_i[HW-1:0]), .value_o(hr_q), .next_o(hr_nx), .carry_o(c_hr));

    tod_field #(.MOD(2), .W(1)) u_meridiem (
        .clk(clk), .rst_n(rst_n), .inc_i(c_hr), .load_i(ld_hr),
        .load_val_i(wdata_i[HOURS_PM_BIT]), .value_o(pm_q), .next_o(pm_nx),
        .carry_o(unused_pm_carry));

    assign live_vec = {pm_q, hr_q, mn_q, sc_q, tn_q};
    assign next_vec = {pm_nx, hr_nx, mn_nx, sc_nx, tn_nx};

    tod_alarm #(.VW(VW)) u_alarm (
        .clk(clk), .rst_n(rst_n), .step_i(step), .en_i(ctl_q.irq_en),
        .clr_i(flag_clr), .next_time_i(next_vec), .alarm_i(ctl_q.alarm), .irq_o(irq_o));

    // Next-state logic for control, alarm and snapshot.
    always_comb begin
        ctl_d     = ctl_q;
        ld_tn     = 1'b0;
        ld_sc     = 1'b0;
        ld_mn     = 1'b0;
        ld_hr     = 1'b0;
        presc_clr = 1'b0;
        flag_clr  = 1'b0;
        if (wr_en_i) begin
            case (addr_i)
                ADDR_TENTHS: begin
                    ld_tn     = 1'b1;
                    ctl_d.run = 1'b1;
                    presc_clr = 1'b1;
                end
                ADDR_SECONDS: ld_sc = 1'b1;
                ADDR_MINUTES: ld_mn = 1'b1;
                ADDR_HOURS: begin
                    ld_hr     = 1'b1;
                    ctl_d.run = 1'b0;
                end
                ADDR_AL_TENTHS:  ctl_d.alarm[TN_LO +: TW] = wdata_i[TW-1:0];
                ADDR_AL_SECONDS: ctl_d.alarm[SC_LO +: SW] = wdata_i[SW-1:0];
                ADDR_AL_MINUTES: ctl_d.alarm[MN_LO +: MW] = wdata_i[MW-1:0];
                ADDR_AL_HOURS: begin
                    ctl_d.alarm[HR_LO +: HW] = wdata_i[HW-1:0];
                    ctl_d.alarm[PM_B]        = wdata_i[HOURS_PM_BIT];
                end
                ADDR_CTRL: begin
                    ctl_d.region = wdata_i[CTRL_REGION_BIT];
                    ctl_d.irq_en = wdata_i[CTRL_IRQEN_BIT];
                    presc_clr    = 1'b1;
                end
                ADDR_STATUS: flag_clr = wdata_i[STATUS_FLAG_BIT];
                default: ;
            endcase
        end
        if (rd_en_i) begin
            if (addr_i == ADDR_HOURS && !ctl_q.frozen) begin
                ctl_d.snap   = live_vec;
                ctl_d.frozen = 1'b1;
            end else if (addr_i == ADDR_TENTHS) begin
                ctl_d.frozen = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q        <= '0;
            ctl_q.run    <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // Read mux.
    always_comb begin
        src_vec = ctl_q.frozen ? ctl_q.snap : live_vec;
        case (addr_i)
            ADDR_TENTHS:     rdata_o = 8'(src_vec[TN_LO +: TW]);
            ADDR_SECONDS:    rdata_o = 8'(src_vec[SC_LO +: SW]);
            ADDR_MINUTES:    rdata_o = 8'(src_vec[MN_LO +: MW]);
            ADDR_HOURS:      rdata_o = {src_vec[PM_B], 7'(src_vec[HR_LO +: HW])};
            ADDR_AL_TENTHS:  rdata_o = 8'(ctl_q.alarm[TN_LO +: TW]);
            ADDR_AL_SECONDS: rdata_o = 8'(ctl_q.alarm[SC_LO +: SW]);
            ADDR_AL_MINUTES: rdata_o = 8'(ctl_q.alarm[MN_LO +: MW]);
            ADDR_AL_HOURS:   rdata_o = {ctl_q.alarm[PM_B], 7'(ctl_q.alarm[HR_LO +: HW])};
            ADDR_CTRL:       rdata_o = {6'b0, ctl_q.irq_en, ctl_q.region};
            ADDR_STATUS:     rdata_o = {7'b0, irq_o};
            default:         rdata_o = 8'h00;
        endcase
    end

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.run && !wr_en_i) |=> $stable(live_vec)) else $error("time moved while halted"); // R6
    AST_SNAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.frozen && !(rd_en_i && addr_i == ADDR_TENTHS))
        |=> (ctl_q.frozen && $stable(ctl_q.snap))) else $error("snapshot disturbed"); // R5

endmodule

// File: tb/tod_clock_test.sv
module tod_clock_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic       rd_en_i = 1'b0;
    logic [3:0] addr_i = 4'd0;
    logic [7:0] wdata_i = 8'd0;
    logic [7:0] rdata_o;
    logic       irq_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    tod_clock #(.TENTHS_MOD(3), .SEC_MOD(4), .MIN_MOD(3), .HOUR_MOD(3)) uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .irq_o(irq_o));

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en_i = 1'b1; addr_i = a;
        #1 d = rdata_o;
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
        end
    endtask

    task automatic check_time(input string rh, input string ro, input int pm,
                              input int hr, input int mn, input int sc, input int tn);
        logic [7:0] d;
        rd(4'd3, d); check(rh, "hours byte", d, pm * 128 + hr);
        rd(4'd2, d); check(ro, "minutes", d, mn);
        rd(4'd1, d); check(ro, "seconds", d, sc);
        rd(4'd0, d); check(ro, "tenths", d, tn);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        for (int a = 0; a < 10; a++) begin
            rd(4'(a), d);
            check("R10", $sformatf("reg %0d after reset", a), d, 0);
        end
        check("R10", "irq after reset", irq_o, 0);

        // R4: alarm and control readback
        wr(4'd4, 8'd2); wr(4'd5, 8'd3); wr(4'd6, 8'd1); wr(4'd7, 8'h82);
        rd(4'd4, d); check("R4", "alarm tenths", d, 2);
        rd(4'd5, d); check("R4", "alarm seconds", d, 3);
        rd(4'd6, d); check("R4", "alarm minutes", d, 1);
        rd(4'd7, d); check("R4", "alarm hours", d, 8'h82);
        rd(4'd12, d); check("R4", "unmapped", d, 0);
        for (int a = 4; a < 8; a++) wr(4'(a), 8'd0);

        // R1/R2/R3: full cycle sweep, divide by 5
        for (int t = 1; t <= 216; t++) begin
            for (int k = 0; k < 5; k++) begin
                if (k == 4 && t <= 4) begin
                    rd(4'd0, d);
                    check("R1", "tenths before 5th tick", d, (t - 1) % 3);
                end
                ticks(1);
            end
            check_time("R3", "R2", (t / 108) % 2, (t / 36) % 3, (t / 12) % 3, (t / 3) % 4, t % 3);
        end

        // R1: divide by 6 and prescaler clear on control write
        wr(4'd8, 8'd1);
        rd(4'd8, d); check("R4", "ctrl readback", d, 1);
        ticks(5); rd(4'd0, d); check("R1", "div6 after 5 ticks", d, 0);
        ticks(1); rd(4'd0, d); check("R1", "div6 after 6 ticks", d, 1);
        ticks(3); wr(4'd8, 8'd1);
        ticks(5); rd(4'd0, d); check("R1", "after ctrl clear 5 ticks", d, 1);
        ticks(1); rd(4'd0, d); check("R1", "after ctrl clear 6 ticks", d, 2);

        // R6: halt on hours write
        wr(4'd3, 8'h82);
        ticks(12);
        check_time("R6", "R6", 1, 2, 0, 0, 2);
        // R9: out of range minutes, restart on tenths write
        wr(4'd2, 8'd3); wr(4'd1, 8'd3); wr(4'd0, 8'd2);
        ticks(5);
        check_time("R6", "R6", 1, 2, 3, 3, 2);
        ticks(6);
        check_time("R3", "R9", 0, 0, 0, 0, 0);

        // R5: snapshot
        ticks(6);
        rd(4'd3, d); check("R5", "hours at freeze", d, 0);
        ticks(12);
        rd(4'd2, d); check("R5", "frozen minutes", d, 0);
        rd(4'd1, d); check("R5", "frozen seconds", d, 0);
        rd(4'd0, d); check("R5", "frozen tenths", d, 1);
        rd(4'd1, d); check("R5", "live seconds", d, 1);
        rd(4'd0, d); check("R5", "live tenths", d, 0);

        // R7: alarm masked
        wr(4'd3, 8'h00); wr(4'd2, 8'd0); wr(4'd1, 8'd0); wr(4'd0, 8'd0);
        wr(4'd4, 8'd1);
        ticks(6);
        check("R7", "masked irq", irq_o, 0);
        rd(4'd9, d); check("R7", "masked status", d, 0);
        rd(4'd0, d); check("R7", "tenths reached alarm", d, 1);

        // R7: alarm enabled
        wr(4'd3, 8'h00); wr(4'd0, 8'd0); wr(4'd8, 8'd3);
        ticks(5); check("R7", "irq before match", irq_o, 0);
        ticks(1); check("R7", "irq on match", irq_o, 1);
        rd(4'd9, d); check("R7", "status on match", d, 1);

        // R8: hold and clear
        ticks(6); check("R8", "irq held", irq_o, 1);
        wr(4'd9, 8'd0); check("R8", "irq after write 0", irq_o, 1);
        wr(4'd9, 8'd1); check("R8", "irq after clear", irq_o, 0);
        rd(4'd9, d); check("R8", "status after clear", d, 0);

        // R7: afternoon flag takes part in the compare
        wr(4'd3, 8'h80); wr(4'd0, 8'd0);
        ticks(6);
        check("R7", "pm mismatch irq", irq_o, 0);
        check_time("R3", "R7", 1, 0, 0, 0, 1);

        finish_run();
    end
endmodule